// File: doc/BRIEF.md
# Multi-Clock Rate Meter

The block measures how fast several independent clocks run by counting their edges over a common window whose length is known in cycles of a bus clock. One enable bit in a control register opens and closes the window. That bit is carried separately into every measured clock domain, and each domain counts its own edges while the enable it sees is high. A counter in the bus domain counts bus cycles over the same window, and that count is the scale for every other count.

When the window closes, each channel marks its count as finished. The bus domain then takes a copy of the count. Every channel has a status bit that says its copy is valid and will not change until the next window. Software divides each channel count by the bus-cycle count and multiplies by the bus clock frequency to get a frequency. That arithmetic is not part of the block.

A channel whose clock is stopped never finishes. Its status bit stays clear and its copy keeps its last value, which is zero after reset. Reads are combinational from bus-domain registers, so a dead clock can never stall the bus.

Top module: `clkrate_meter`

## Requirements
- R1: After reset the enable bit, every status bit, every overflow flag, the bus-cycle count and every channel count read as zero.
- R2: A write to offset 0 loads the enable from write-data bit 0, and reading offset 0 returns the enable in bit 0.
- R3: The count read at offset 1 is cleared by the write that raises the enable. It then equals the number of bus cycles the enable was high, and it holds once the enable is low.
- R4: The count of channel i, read at offset 2+i, equals the number of its own clock cycles within the window, give or take 3.
- R5: Every count saturates at all-ones and never wraps.
- R6: Bit 16 of offset 0 reads 1 exactly when the bus-cycle count is all-ones. Bit 17+i reads 1 exactly when channel i's count is all-ones. This includes a window that closes on the very cycle the bus-cycle count reaches all-ones.
- R7: Bit 8+i of offset 0 is set once channel i's count has been captured after the window closes. While it is set, that count does not change.
- R8: A channel whose clock does not toggle keeps its status bit clear and its count at zero after reset, and reads of it return at once.
- R9: The write that raises the enable clears every status bit, and no status bit is set while the enable is high.
- R10: Reads of offsets above 1+NCH return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus and reference clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| meas_clk | input | NCH | One clock per measured channel |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The last increment that takes the bus-cycle count to all-ones can fall in the same cycle as the write that closes the window. The bench provokes this with windows of exactly 254, 255 and 300 bus cycles at an 8-bit count width. It expects 254 with the overflow flag clear, 255 with the flag set, and 255 again with no wrap. A behavioural model of the enable and the bus-cycle count is compared against the read port on every clock, so a window that ends one cycle early or late shows up at once.

// File: rtl/clkm_pkg.sv
package clkm_pkg;
    localparam int DATA_W   = 32;
    localparam int OFS_CTRL = 0;
    localparam int OFS_REF  = 1;
    localparam int OFS_CH0  = 2;
    localparam int BIT_EN   = 0;
    localparam int STAT_LSB = 8;
    localparam int OVF_LSB  = 16;
endpackage

// File: rtl/clkm_sync.sv
module clkm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/clkm_chan.sv
module clkm_chan #(
    parameter int CNT_W = 32
) (
    input  logic             mclk,
    input  logic             arst_n,
    input  logic             en_async,
    output logic [CNT_W-1:0] cnt,
    output logic             held
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic             en_prev;
        logic             held;
        logic [CNT_W-1:0] cnt;
    } chan_t;

    logic  mrst_n, en_s;
    chan_t st_d, st_q;

    // reset released in this clock's own domain
    clkm_sync u_rst (.clk(mclk), .rst_n(arst_n), .d(1'b1),     .q(mrst_n));
    clkm_sync u_en  (.clk(mclk), .rst_n(mrst_n), .d(en_async), .q(en_s));

    always_comb begin
        st_d         = st_q;
        st_d.en_prev = en_s;
        if (en_s && !st_q.en_prev) begin
            st_d.cnt  = CNT_ONE;
            st_d.held = 1'b0;
        end else if (en_s) begin
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + CNT_ONE;
        end else if (st_q.en_prev) begin
            st_d.held = 1'b1;
        end
    end

    always_ff @(posedge mclk or negedge mrst_n) begin
        if (!mrst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign held = st_q.held;
endmodule

// File: rtl/clkrate_meter.sv
module clkrate_meter
    import clkm_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic [NCH-1:0]    meas_clk,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [CNT_W-1:0]  CNT_MAX = '1;
    localparam logic [CNT_W-1:0]  CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_REF   = ADDR_W'(OFS_REF);
    localparam logic [ADDR_W-1:0] A_CH0   = ADDR_W'(OFS_CH0);

    typedef struct packed {
        logic                       en;
        logic [CNT_W-1:0]           ref_cnt;
        logic [NCH-1:0]             rdy_prev;
        logic [NCH-1:0]             status;
        logic [NCH-1:0][CNT_W-1:0]  cap;
    } bus_t;

    bus_t st_d, st_q;
    logic [NCH-1:0][CNT_W-1:0] chan_cnt;
    logic [NCH-1:0]            chan_held;
    logic [NCH-1:0]            held_s;
    logic                      ctrl_wr, win_start;
    logic                      wdata_unused;

    // signals seen by the bound checker
    logic                      en_q;
    logic [CNT_W-1:0]          ref_q;
    logic [NCH-1:0]            status_q;
    logic [NCH-1:0][CNT_W-1:0] cap_q;

    assign wdata_unused = ^bus_wdata[DATA_W-1:1];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        clkm_chan #(.CNT_W(CNT_W)) u_chan (
            .mclk     (meas_clk[g]),
            .arst_n   (bus_rst_n),
            .en_async (st_q.en),
            .cnt      (chan_cnt[g]),
            .held     (chan_held[g])
        );
        clkm_sync u_back (
            .clk   (bus_clk),
            .rst_n (bus_rst_n),
            .d     (chan_held[g]),
            .q     (held_s[g])
        );
    end

    assign ctrl_wr   = bus_wr && (bus_addr == A_CTRL);
    assign win_start = ctrl_wr && bus_wdata[BIT_EN] && !st_q.en;

    always_comb begin
        st_d          = st_q;
        st_d.rdy_prev = held_s;
        if (st_q.en && (st_q.ref_cnt != CNT_MAX)) st_d.ref_cnt = st_q.ref_cnt + CNT_ONE;
        if (ctrl_wr) st_d.en = bus_wdata[BIT_EN];
        if (win_start) begin
            st_d.ref_cnt = '0;
            st_d.status  = '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                // channel count is frozen once its done flag is seen rising
                if (held_s[i] && !st_q.rdy_prev[i] && !st_q.en) begin
                    st_d.cap[i]    = chan_cnt[i];
                    st_d.status[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) begin
            bus_rdata[BIT_EN]         = st_q.en;
            bus_rdata[STAT_LSB +: NCH] = st_q.status;
            bus_rdata[OVF_LSB]        = (st_q.ref_cnt == CNT_MAX);
            for (int i = 0; i < NCH; i++)
                bus_rdata[OVF_LSB+1+i] = (st_q.cap[i] == CNT_MAX);
        end else if (bus_addr == A_REF) begin
            bus_rdata[CNT_W-1:0] = st_q.ref_cnt;
        end else begin
            for (int i = 0; i < NCH; i++)
                if (bus_addr == A_CH0 + ADDR_W'(i)) bus_rdata[CNT_W-1:0] = st_q.cap[i];
        end
    end

    assign en_q     = st_q.en;
    assign ref_q    = st_q.ref_cnt;
    assign status_q = st_q.status;
    assign cap_q    = st_q.cap;
endmodule

// File: rtl/clkrate_meter_chk.sv
module clkrate_meter_chk #(
    parameter int NCH   = 3,
    parameter int CNT_W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ctrl_wr,
    input logic                      wbit,
    input logic                      start,
    input logic                      en,
    input logic [CNT_W-1:0]          ref_cnt,
    input logic [NCH-1:0]            status,
    input logic [NCH-1:0][CNT_W-1:0] cap
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    p_en_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (en == $past(wbit)));

    p_ref_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (ref_cnt == '0));

    p_ref_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !start && ref_cnt != CNT_MAX) |=> (ref_cnt == $past(ref_cnt) + 1'b1));

    p_ref_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !start) |=> $stable(ref_cnt));

    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_cnt == CNT_MAX && !start) |=> (ref_cnt == CNT_MAX));

    p_quiet_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (status == '0));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        p_cap_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (status[g] && !start) |=> $stable(cap[g]));
    end
endmodule

bind clkrate_meter clkrate_meter_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk     (bus_clk),
    .rst_n   (bus_rst_n),
    .ctrl_wr (ctrl_wr),
    .wbit    (bus_wdata[0]),
    .start   (win_start),
    .en      (en_q),
    .ref_cnt (ref_q),
    .status  (status_q),
    .cap     (cap_q)
);

// File: tb/test_clkrate_meter.sv
module test_clkrate_meter;
    localparam int NCH = 3;
    localparam int CNT_W = 8;
    localparam int ADDR_W = 4;
    localparam int MAXV = 255;

    logic              clk = 1'b0, rst_n = 1'b0, wr = 1'b0;
    logic              c0 = 1'b0, c1 = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0, rdata;
    logic [NCH-1:0]    mclk;
    int total = 0, bad = 0;
    int en_m = 0, ref_m = 0;

    assign mclk = {1'b0, c1, c0};   // channel 2 is a dead clock

    always #4 clk = ~clk;   // 125 MHz bus clock
    always #5 c0 = ~c0;     // 100 MHz
    always #3 c1 = ~c1;     // ~166.7 MHz

    clkrate_meter #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_clkrate_meter (
        .bus_clk(clk), .bus_rst_n(rst_n), .meas_clk(mclk),
        .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata));

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_near(input string tag, input int act, input int exp, input int tol);
        total++;
        if (act < exp - tol || act > exp + tol) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d+-%0d", tag, act, exp, tol);
        end
    endtask

    // behavioural model of enable and bus-cycle count, compared every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            en_m = 0; ref_m = 0;
        end else begin
            if (en_m != 0 && ref_m < MAXV) ref_m = ref_m + 1;
            if (wr && addr == 0) begin
                if (wdata[0] && en_m == 0) ref_m = 0;
                en_m = int'(wdata[0]);
            end
        end
        #2;
        if (rst_n) begin
            if (addr == 1) chk("R3 model ref count", int'(rdata), ref_m);
            if (addr == 0) chk("R2 model enable", int'(rdata[0]), en_m);
        end
    end

    // called just after a falling edge; returns just after the next one
    task automatic bwrite(input int a, input int d);
        wr = 1'b1; addr = ADDR_W'(a); wdata = 32'(d);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bread(input int a, output int d);
        addr = ADDR_W'(a);
        #1;
        d = int'(rdata);
        @(negedge clk);
    endtask

    task automatic window(input int n);
        bwrite(0, 1);
        repeat (n - 1) @(negedge clk);
        bwrite(0, 0);
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int v, c0v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int a = 0; a < 5; a++) begin
            bread(a, v);
            chk($sformatf("R1 reset value at offset %0d", a), v, 0);
        end

        // first window: 100 bus cycles
        bwrite(0, 1);
        bread(0, v);
        chk("R2 enable reads back set", v & 1, 1);
        chk("R9 no status while window open", (v >> 8) & 7, 0);
        repeat (98) @(negedge clk);
        bwrite(0, 0);
        repeat (20) @(negedge clk);

        bread(0, v);
        chk("R2 enable reads back clear", v & 1, 0);
        chk("R7 status of live channels set", (v >> 8) & 7, 3);
        chk("R6 no overflow flags", (v >> 16) & 15, 0);
        bread(1, v);
        chk("R3 bus-cycle count", v, 100);
        bread(2, c0v);
        chk_near("R4 channel 0 count", c0v, 80, 3);
        bread(3, v);
        chk_near("R4 channel 1 count", v, 133, 3);
        bread(4, v);
        chk("R8 dead channel count", v, 0);
        bread(7, v);
        chk("R10 unused offset 7", v, 0);
        bread(15, v);
        chk("R10 unused offset 15", v, 0);
        repeat (10) @(negedge clk);
        bread(2, v);
        chk("R7 captured count stable", v, c0v);

        // second window: 254 cycles, one short of saturation
        bwrite(0, 1);
        bread(0, v);
        chk("R9 restart clears status", (v >> 8) & 7, 0);
        repeat (252) @(negedge clk);
        bwrite(0, 0);
        repeat (20) @(negedge clk);
        bread(1, v);
        chk("R3 count one below all-ones", v, 254);
        bread(0, v);
        chk("R6 reference flag clear at 254", (v >> 16) & 1, 0);
        chk("R6 channel 0 flag clear", (v >> 17) & 1, 0);
        chk("R6 channel 1 flag set", (v >> 18) & 1, 1);
        chk("R7 status set after second window", (v >> 8) & 7, 3);
        bread(3, v);
        chk("R5 channel 1 saturates", v, MAXV);
        bread(2, v);
        chk_near("R4 channel 0 long window", v, 203, 3);

        // close on the cycle the reference reaches all-ones
        window(255);
        repeat (20) @(negedge clk);
        bread(1, v);
        chk("R6 reference reaches all-ones at close", v, MAXV);
        bread(0, v);
        chk("R6 reference flag set at close", (v >> 16) & 1, 1);

        window(300);
        repeat (20) @(negedge clk);
        bread(1, v);
        chk("R5 reference does not wrap", v, MAXV);
        bread(0, v);
        chk("R8 dead channel status clear", (v >> 10) & 1, 0);
        chk("R6 dead channel flag clear", (v >> 19) & 1, 0);
        bread(4, v);
        chk("R8 dead channel still zero", v, 0);

        finish_run();
    end
endmodule